// File: doc/BRIEF.md
# Bit-Serial Polynomial-Basis Field Multiplier

This block multiplies two elements of the binary extension field GF(2^163) and returns their product reduced modulo the fixed pentanomial x^163 + x^7 + x^6 + x^3 + 1. It handles one bit of the second operand per clock cycle, starting with the top bit. In that same cycle it folds the partial product back below degree 163, so no double-width intermediate ever exists. Squaring needs no separate unit: the caller presents the same value on both operand inputs.

The caller raises `start` for one cycle while the unit is idle. The unit then latches both operands and clears its accumulator. After exactly M steps it writes the result register and raises `done` for one cycle. The field degree and the reduction polynomial are parameters, so a four-bit field (x^4 + x + 1) can be built from the same source for exhaustive checking.

Top module: `gf2m_serial_mul`

## Requirements
- R1: After synchronous reset, `busy` is 0, `done` is 0 and `result` is all zeros.
- R2: For any operands a and b of degree below M, `result` equals the carry-less product a·b reduced modulo the polynomial given by parameter POLY. By default M = 163 and POLY has bits 163, 7, 6, 3 and 0 set.
- R3: Built with M = 4 and POLY = 5'b10011, the unit gives the correct product for all 256 operand pairs.
- R4: A `start` sampled while idle makes `busy` read 1 after that edge. `busy` stays 1 for M cycles. `done` rises exactly M clock edges after the accepting edge, and at that point `busy` is 0.
- R5: `done` is high for a single cycle. `result` changes only in the cycle where `done` rises, and otherwise keeps its value.
- R6: A `start` seen while `busy` is 1 is ignored. The run in progress still returns the product of the operands latched when it began, and no extra completion follows.
- R7: Feeding equal operands yields the field square, with the same latency as a general product.
- R8: Multiplying by the zero element gives zero. Multiplying by the element 1 gives the other operand unchanged.
- R9: A new `start` may be given in the cycle after `done`. That request is accepted and completes normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a product; only acted on while idle |
| op_a | input | M | Multiplicand, latched on acceptance |
| op_b | input | M | Multiplier, latched on acceptance and scanned top bit first |
| busy | output | 1 | High while a product is being computed |
| done | output | 1 | One-cycle pulse when `result` is written |
| result | output | M | Reduced product, held until the next completion |

## Verification
Several properties are checked on every cycle:
- the length of each run against an independent counter;
- `busy` being set after an accepted start;
- `done` being a single-cycle pulse that never overlaps `busy`;
- `result` staying unchanged outside completion cycles.

Whether the arithmetic is right is shown only by the bench scenarios. These compare against a schoolbook product followed by a separate top-down reduction, over random operands, identity and zero operands, squares, top-degree bits, and every pair in the four-bit field. The bench scenarios also cover mid-run start requests being ignored and back-to-back starts.

// File: rtl/gf2m_mul_pkg.sv
package gf2m_mul_pkg;

  localparam int unsigned K163_M = 163;

  localparam logic [K163_M:0] K163_POLY =
    (164'd1 << 163) | (164'd1 << 7) | (164'd1 << 6) | (164'd1 << 3) | 164'd1;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;

endpackage

// File: rtl/gf2m_mul_ctrl.sv
module gf2m_mul_ctrl #(
  parameter int unsigned M = 163
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic load,
  output logic step_en,
  output logic last,
  output logic busy
);
  import gf2m_mul_pkg::*;

  localparam int unsigned CW = $clog2(M + 1);

  run_state_e    state_q;
  logic [CW-1:0] cnt_q;

  assign load    = (state_q == ST_IDLE) && start;
  assign step_en = (state_q == ST_RUN);
  assign last    = step_en && (cnt_q == CW'(0));
  assign busy    = step_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_RUN;
            cnt_q   <= CW'(M - 1);
          end
        end
        default: begin
          if (cnt_q == CW'(0)) state_q <= ST_IDLE;
          else                 cnt_q   <= cnt_q - CW'(1);
        end
      endcase
    end
  end

  // Independent run-length counter used only by the checks below
  logic [CW-1:0] run_len_q;
  always_ff @(posedge clk) begin
    if (rst)          run_len_q <= '0;
    else if (load)    run_len_q <= '0;
    else if (step_en) run_len_q <= run_len_q + CW'(1);
  end

  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (rst) last |-> (run_len_q == CW'(M - 1))); // R4
  AST_RUN_ENTERED: assert property (@(posedge clk) disable iff (rst) load |=> busy); // R4

endmodule

// File: rtl/gf2m_mul_step.sv
module gf2m_mul_step #(
  parameter int unsigned   M    = 163,
  parameter logic [M:0]    POLY = gf2m_mul_pkg::K163_POLY
) (
  input  logic [M:0]   acc,
  input  logic [M-1:0] mcand,
  input  logic         mbit,
  output logic [M:0]   acc_nxt
);
  logic [M:0] dbl;
  logic [M:0] sum;

  assign dbl = {acc[M-1:0], 1'b0};

  generate
    for (genvar i = 0; i <= M; i++) begin : g_bit
      if (i < M) begin : g_low
        assign sum[i] = dbl[i] ^ (mbit & mcand[i]);
      end else begin : g_top
        assign sum[i] = dbl[i];
      end
      assign acc_nxt[i] = sum[i] ^ (sum[M] & POLY[i]);
    end
  endgenerate

endmodule

// File: rtl/gf2m_mul_datapath.sv
module gf2m_mul_datapath #(
  parameter int unsigned   M    = 163,
  parameter logic [M:0]    POLY = gf2m_mul_pkg::K163_POLY
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step_en,
  input  logic [M-1:0] op_a,
  input  logic [M-1:0] op_b,
  output logic [M:0]   acc_nxt
);
  logic [M-1:0] mcand_q;
  logic [M-1:0] mplier_q;
  logic [M:0]   acc_q;

  gf2m_mul_step #(.M(M), .POLY(POLY)) u_step (
    .acc     (acc_q),
    .mcand   (mcand_q),
    .mbit    (mplier_q[M-1]),
    .acc_nxt (acc_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand_q  <= '0;
      mplier_q <= '0;
      acc_q    <= '0;
    end else if (load) begin
      mcand_q  <= op_a;
      mplier_q <= op_b;
      acc_q    <= '0;
    end else if (step_en) begin
      mplier_q <= {mplier_q[M-2:0], 1'b0};
      acc_q    <= acc_nxt;
    end
  end

endmodule

// File: rtl/gf2m_serial_mul.sv
module gf2m_serial_mul #(
  parameter int unsigned   M    = gf2m_mul_pkg::K163_M,
  parameter logic [M:0]    POLY = gf2m_mul_pkg::K163_POLY
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [M-1:0] op_a,
  input  logic [M-1:0] op_b,
  output logic         busy,
  output logic         done,
  output logic [M-1:0] result
);
  logic       load;
  logic       step_en;
  logic       last;
  logic [M:0] acc_nxt;

  gf2m_mul_ctrl #(.M(M)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .load    (load),
    .step_en (step_en),
    .last    (last),
    .busy    (busy)
  );

  gf2m_mul_datapath #(.M(M), .POLY(POLY)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .step_en (step_en),
    .op_a    (op_a),
    .op_b    (op_b),
    .acc_nxt (acc_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= last;
      if (last) result <= acc_nxt[M-1:0];
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R5
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst) !done |-> $stable(result)); // R5
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst) done |-> !busy); // R4
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst) (busy && !last) |=> busy); // R6

endmodule

// File: tb/gf2m_serial_mul_test.sv
module gf2m_serial_mul_test;
  localparam int M = 163;
  localparam logic [M:0] POLY = (164'd1 << 163) | 164'h0C9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_bad = 0;

  // Large-field unit
  logic         start = 1'b0;
  logic [M-1:0] op_a = '0, op_b = '0;
  logic         busy, done;
  logic [M-1:0] result;

  gf2m_serial_mul #(.M(M), .POLY(POLY)) uut (
    .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
    .busy(busy), .done(done), .result(result)
  );

  // Four-bit field unit
  logic       s_start = 1'b0;
  logic [3:0] s_a = '0, s_b = '0;
  logic       s_busy, s_done;
  logic [3:0] s_res;

  gf2m_serial_mul #(.M(4), .POLY(5'b10011)) uut_small (
    .clk(clk), .rst(rst), .start(s_start), .op_a(s_a), .op_b(s_b),
    .busy(s_busy), .done(s_done), .result(s_res)
  );

  // Schoolbook product, then top-down reduction
  function automatic logic [M-1:0] ref_mul(input logic [M-1:0] a, input logic [M-1:0] b,
                                           input int m, input logic [M:0] poly);
    logic [2*M-1:0] p;
    p = '0;
    for (int i = 0; i < m; i++)
      if (b[i]) p = p ^ ((2*M)'(a) << i);
    for (int d = 2*m - 2; d >= m; d--)
      if (p[d]) p = p ^ ((2*M)'(poly) << (d - m));
    return p[M-1:0];
  endfunction

  function automatic logic [M-1:0] rand_elem();
    logic [M-1:0] r;
    for (int k = 0; k < M; k++) r[k] = 1'($urandom);
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [M-1:0] act, input logic [M-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct {
    logic [M-1:0] exp;
    int           t0;
    string        req;
  } item_t;
  item_t sb_q[$];

  // Monitor: pops expected items as completions arrive
  always @(negedge clk) begin
    if (!rst && done) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R6 spurious done", result, '0);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        check(result == it.exp, it.req, result, it.exp);
        check((cyc - it.t0) == M, "R4 latency", M'(cyc - it.t0), M'(M));
      end
    end
  end

  // Driver: issue one product, push its expected value
  task automatic drive(input logic [M-1:0] a, input logic [M-1:0] b, input string req);
    while (busy) @(negedge clk);
    start = 1'b1; op_a = a; op_b = b;
    @(posedge clk); #1;
    sb_q.push_back('{exp: ref_mul(a, b, M, POLY), t0: cyc, req: req});
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R4 busy after start", M'(busy), M'(1));
  endtask

  task automatic drain();
    while (sb_q.size() != 0) @(negedge clk);
  endtask

  initial begin : watchdog
    #(5ns * 150000);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [M-1:0] x0, y0, hold;
    x0 = 163'h2FE13C0537BBC11ACAA07D793DE4E6D5E5C94EEE8;
    y0 = 163'h289070FB05D38FF58321F2E800536D538CCDAA3D9;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(busy == 0 && done == 0, "R1 flags", {busy, done}, '0);
    check(result == '0, "R1 result", result, '0);
    check(s_busy == 0 && s_done == 0 && s_res == 0, "R1 small unit", {s_busy, s_done, s_res}, '0);

    // R2 general products
    drive(x0, y0, "R2 fixed pair");
    for (int k = 0; k < 12; k++) drive(rand_elem(), rand_elem(), "R2 random");
    drive({1'b1, 162'd0}, {1'b1, 162'd0}, "R2 top bits");
    drive('1, '1, "R2 all ones");
    // R8 identities
    drive(x0, '0, "R8 times zero");
    drive(M'(1), y0, "R8 one times b");
    drive(x0, M'(1), "R8 a times one");
    // R7 squares
    drive(x0, x0, "R7 square x");
    drive('1, '1, "R7 square ones");
    drive(y0, y0, "R7 square y");
    // R9 back to back: drive resumes right after done
    drive(y0, x0, "R9 back to back 1");
    drive(x0 ^ y0, y0, "R9 back to back 2");
    drain();

    // R5 done pulses once, result holds
    hold = result;
    @(negedge clk);
    check(done == 1'b0, "R5 done single cycle", M'(done), '0);
    repeat (5) @(negedge clk);
    check(result == hold, "R5 result held", result, hold);

    // R6 start during a run is ignored
    drive(x0, y0, "R6 original operands kept");
    repeat (10) @(negedge clk);
    start = 1'b1; op_a = '1; op_b = M'(3);
    @(negedge clk);
    start = 1'b0;
    drain();
    repeat (M + 10) @(negedge clk);
    check(busy == 1'b0, "R6 no extra run", M'(busy), '0);

    // R3 exhaustive four-bit field
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        logic [3:0] e;
        int t0, lat;
        e = 4'(ref_mul(M'(a), M'(b), 4, M'(5'b10011)));
        while (s_busy) @(negedge clk);
        s_start = 1'b1; s_a = 4'(a); s_b = 4'(b);
        @(posedge clk); #1; t0 = cyc;
        @(negedge clk); s_start = 1'b0;
        while (!s_done) @(negedge clk);
        lat = cyc - t0;
        check(s_res == e && lat == 4, "R3 small field", M'({lat[7:0], s_res}), M'({8'd4, e}));
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule